// File: doc/BRIEF.md
# Readout Word Window Selector

This block decides, for one board, whether the decision-logic readout word for a given bunch-crossing offset is written into the data-acquisition record. It also decides whether the word is written into the event-manager record, and it formats the bunch-crossing number carried in that word. The offset is a signed distance from the triggered crossing. Each board has a slot in two masks: one says whether the board is active, the other picks which of two record lengths applies to it. The chosen length sets a window of offsets that is slightly asymmetric around zero. The data-acquisition write happens only when the offset lies inside that window. The event-manager path looks at the active bit alone and applies no window.

The bunch-crossing field is 12 bits wide. If the raw number does not fit in 12 bits, the field is set to zero instead of keeping the low bits. The local bunch-crossing field carries the same value as the absolute field. Every output is registered, so the results for one set of inputs appear together one clock after those inputs are presented. The record storage and the other fields of the word are handled elsewhere.

Top module: `rdo_win_sel`

## Requirements
- R1: The board counts as active only when `board_pos_i` (two's complement) is non-negative, is below NUM_BOARDS, and bit `board_pos_i` of `active_mask_i` is 1. `evm_we_o` equals this active flag, and no window is applied to it.
- R2: If bit `board_pos_i` of `alt_len_mask_i` is 1, the record length L is `rec_len1_i`. Otherwise L is `rec_len0_i`.
- R3: The offset window is lo = (L+1)/2 − L to hi = (L+1)/2 − 1, inclusive at both ends, using integer division that truncates. For example, L=1 gives 0..0, L=4 gives −2..1 and L=15 gives −7..7.
- R4: `daq_we_o` is 1 exactly when the board is active and `bx_ofs_i` (two's complement) lies within the window.
- R5: A record length of 0 gives an empty window, so `daq_we_o` stays 0 whatever the offset.
- R6: A `bx_raw_i` value above 4095 produces `bx_nr_o` = 0. The low bits are not kept.
- R7: A `bx_raw_i` value from 0 to 4095 is passed to `bx_nr_o` unchanged.
- R8: `bx_local_o` always equals `bx_nr_o`.
- R9: All outputs are 0 while `rst_ni` is low. After reset, the outputs for the inputs sampled at one rising edge are visible after that edge, all in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bx_ofs_i | input | 5 | Signed bunch-crossing offset |
| active_mask_i | input | 16 | Active-board mask, one bit per board |
| alt_len_mask_i | input | 16 | Length-select mask, 1 selects record length 1 |
| rec_len0_i | input | 4 | Record length 0 |
| rec_len1_i | input | 4 | Record length 1 |
| board_pos_i | input | 5 | Signed bit position of this board in the masks |
| bx_raw_i | input | 16 | Raw bunch-crossing number |
| daq_we_o | output | 1 | Data-acquisition record write enable |
| evm_we_o | output | 1 | Event-manager record write enable |
| bx_nr_o | output | 12 | Absolute bunch-crossing field |
| bx_local_o | output | 12 | Local bunch-crossing field |

## Verification
Each output is due one rising edge after its inputs are sampled. The bench drives each vector on a falling edge and compares all four outputs on the next falling edge. At that point exactly one register stage has captured the vector and the next vector has not yet reached the registers. The expected write enables and bunch-crossing fields come from a bench function that evaluates the window formula with integers. The stimulus is random, mixed with directed vectors at the window edges, at length zero, at negative and out-of-range positions, and at the 4095/4096 bunch-crossing limit.

// File: rtl/rdo_win_pkg.sv
package rdo_win_pkg;
  localparam int unsigned BX_FIELD_W = 12;
  localparam int unsigned REC_LEN_W  = 4;

  typedef struct packed {
    logic                  daq_we;
    logic                  evm_we;
    logic [BX_FIELD_W-1:0] bx_nr;
    logic [BX_FIELD_W-1:0] bx_local;
  } rdo_out_t;
endpackage

// File: rtl/rdo_board_sel.sv
module rdo_board_sel #(
  parameter int unsigned NUM_BOARDS = 16,
  parameter int unsigned POS_W      = $clog2(NUM_BOARDS) + 1
) (
  input  logic signed [POS_W-1:0]      pos_i,
  input  logic        [NUM_BOARDS-1:0] active_mask_i,
  input  logic        [NUM_BOARDS-1:0] alt_mask_i,
  output logic                         active_o,
  output logic                         alt_o
);
  localparam int unsigned IDX_W = POS_W - 1;

  logic [IDX_W-1:0] idx;
  logic             pos_ok;

  assign idx    = pos_i[IDX_W-1:0];
  // negative position or slot beyond the mask: board absent
  assign pos_ok = !pos_i[POS_W-1] && (32'(idx) < NUM_BOARDS);

  always_comb begin
    active_o = 1'b0;
    alt_o    = 1'b0;
    if (pos_ok) begin
      active_o = active_mask_i[idx];
      alt_o    = alt_mask_i[idx];
    end
  end
endmodule

// File: rtl/rdo_window.sv
module rdo_window #(
  parameter int unsigned LEN_W = 4,
  parameter int unsigned OFS_W = 5
) (
  input  logic              [LEN_W-1:0] len_i,
  input  logic signed       [OFS_W-1:0] ofs_i,
  output logic                          in_win_o
);
  localparam int unsigned CW = ((OFS_W > LEN_W + 1) ? OFS_W : LEN_W + 1) + 1;

  logic signed [CW-1:0] len_s, half_s, lo_s, hi_s, ofs_s;

  always_comb begin
    len_s  = signed'({{(CW-LEN_W){1'b0}}, len_i});
    ofs_s  = signed'({{(CW-OFS_W){ofs_i[OFS_W-1]}}, ofs_i});
    half_s = (len_s + CW'(1)) >>> 1;
    lo_s   = half_s - len_s;
    hi_s   = half_s - CW'(1);
    in_win_o = (ofs_s >= lo_s) && (ofs_s <= hi_s);
  end

  always_comb begin
    if (len_i == '0) begin
      AST_LEN_ZERO_EMPTY: assert (!in_win_o); // R5
    end
  end
endmodule

// File: rtl/rdo_bx_fmt.sv
module rdo_bx_fmt #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned OUT_W = 12
) (
  input  logic [IN_W-1:0]  bx_raw_i,
  output logic [OUT_W-1:0] bx_o
);
  generate
    if (IN_W > OUT_W) begin : g_clamp
      logic fits;
      assign fits = (bx_raw_i[IN_W-1:OUT_W] == '0);
      assign bx_o = fits ? bx_raw_i[OUT_W-1:0] : '0;
    end else begin : g_pass
      assign bx_o = OUT_W'(bx_raw_i);
    end
  endgenerate
endmodule

// File: rtl/rdo_win_sel.sv
module rdo_win_sel
  import rdo_win_pkg::*;
#(
  parameter int unsigned NUM_BOARDS = 16,
  parameter int unsigned OFS_W      = 5,
  parameter int unsigned BX_IN_W    = 16,
  localparam int unsigned POS_W     = $clog2(NUM_BOARDS) + 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic signed [OFS_W-1:0]      bx_ofs_i,
  input  logic        [NUM_BOARDS-1:0] active_mask_i,
  input  logic        [NUM_BOARDS-1:0] alt_len_mask_i,
  input  logic        [REC_LEN_W-1:0]  rec_len0_i,
  input  logic        [REC_LEN_W-1:0]  rec_len1_i,
  input  logic signed [POS_W-1:0]      board_pos_i,
  input  logic        [BX_IN_W-1:0]    bx_raw_i,
  output logic                         daq_we_o,
  output logic                         evm_we_o,
  output logic        [BX_FIELD_W-1:0] bx_nr_o,
  output logic        [BX_FIELD_W-1:0] bx_local_o
);
  localparam logic [BX_IN_W-1:0] BX_MAX = BX_IN_W'((1 << BX_FIELD_W) - 1);

  logic                  active, alt, in_win;
  logic [REC_LEN_W-1:0]  len_sel;
  logic [BX_FIELD_W-1:0] bx_fmt;
  rdo_out_t              out_d, out_q;

  rdo_board_sel #(.NUM_BOARDS(NUM_BOARDS), .POS_W(POS_W)) u_board_sel (
    .pos_i         (board_pos_i),
    .active_mask_i (active_mask_i),
    .alt_mask_i    (alt_len_mask_i),
    .active_o      (active),
    .alt_o         (alt)
  );

  assign len_sel = alt ? rec_len1_i : rec_len0_i;

  rdo_window #(.LEN_W(REC_LEN_W), .OFS_W(OFS_W)) u_window (
    .len_i    (len_sel),
    .ofs_i    (bx_ofs_i),
    .in_win_o (in_win)
  );

  rdo_bx_fmt #(.IN_W(BX_IN_W), .OUT_W(BX_FIELD_W)) u_bx_fmt (
    .bx_raw_i (bx_raw_i),
    .bx_o     (bx_fmt)
  );

  always_comb begin
    out_d.daq_we   = active & in_win;
    out_d.evm_we   = active;
    out_d.bx_nr    = bx_fmt;
    out_d.bx_local = bx_fmt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= out_d;
  end

  assign daq_we_o   = out_q.daq_we;
  assign evm_we_o   = out_q.evm_we;
  assign bx_nr_o    = out_q.bx_nr;
  assign bx_local_o = out_q.bx_local;

  AST_DAQ_NEEDS_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    daq_we_o |-> evm_we_o); // R4
  AST_NEG_POS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (board_pos_i < 0) |=> (!daq_we_o && !evm_we_o)); // R1
  AST_LEN_ZERO_NO_DAQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_len0_i == '0 && rec_len1_i == '0) |=> !daq_we_o); // R5
  AST_BX_TOO_BIG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bx_raw_i > BX_MAX) |=> (bx_nr_o == '0)); // R6
  AST_BX_FITS_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bx_raw_i <= BX_MAX) |=> (bx_nr_o == $past(bx_raw_i[BX_FIELD_W-1:0]))); // R7
  AST_LOCAL_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bx_local_o == bx_nr_o); // R8
endmodule

// File: tb/rdo_win_sel_tb.sv
module rdo_win_sel_tb;
  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic signed [4:0] bx_ofs_i = '0;
  logic [15:0]       active_mask_i = '0;
  logic [15:0]       alt_len_mask_i = '0;
  logic [3:0]        rec_len0_i = '0;
  logic [3:0]        rec_len1_i = '0;
  logic signed [4:0] board_pos_i = '0;
  logic [15:0]       bx_raw_i = '0;
  logic              daq_we_o, evm_we_o;
  logic [11:0]       bx_nr_o, bx_local_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  rdo_win_sel u_dut (
    .clk_i, .rst_ni, .bx_ofs_i, .active_mask_i, .alt_len_mask_i,
    .rec_len0_i, .rec_len1_i, .board_pos_i, .bx_raw_i,
    .daq_we_o, .evm_we_o, .bx_nr_o, .bx_local_o
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit ref_active(int pos, logic [15:0] m);
    return (pos >= 0 && pos < 16) ? m[pos] : 1'b0;
  endfunction

  function automatic bit ref_daq(int pos, int ofs, logic [15:0] am, logic [15:0] lm, int l0, int l1);
    int len, lo, hi;
    if (!ref_active(pos, am)) return 1'b0;
    len = lm[pos] ? l1 : l0; // R2
    lo  = (len + 1) / 2 - len; // R3
    hi  = (len + 1) / 2 - 1;
    return (ofs >= lo && ofs <= hi);
  endfunction

  function automatic int ref_bx(int raw);
    return (raw <= 4095) ? raw : 0;
  endfunction

  task automatic apply(int ofs, logic [15:0] am, logic [15:0] lm, int l0, int l1, int pos, int raw, string tag);
    @(negedge clk_i);
    bx_ofs_i = 5'(ofs); active_mask_i = am; alt_len_mask_i = lm;
    rec_len0_i = 4'(l0); rec_len1_i = 4'(l1); board_pos_i = 5'(pos); bx_raw_i = 16'(raw);
    @(negedge clk_i);
    chk({tag, " R4 R3 R2 daq_we"}, int'(daq_we_o), int'(ref_daq(pos, ofs, am, lm, l0, l1)));
    chk({tag, " R1 R9 evm_we"}, int'(evm_we_o), int'(ref_active(pos, am)));
    chk({tag, " R6 R7 bx_nr"}, int'(bx_nr_o), ref_bx(raw));
    chk({tag, " R8 bx_local"}, int'(bx_local_o), int'(bx_nr_o));
  endtask

  initial begin
    void'($urandom(32'd1234));
    #23;
    chk("R9 reset daq_we", int'(daq_we_o), 0);
    chk("R9 reset evm_we", int'(evm_we_o), 0);
    chk("R9 reset bx_nr", int'(bx_nr_o), 0);
    rst_ni = 1'b1;
    // R3 window edges, L=15 -> -7..7
    apply(-7, 16'hFFFF, 16'h0000, 15, 0, 3, 100, "R3 lo15");
    apply(-8, 16'hFFFF, 16'h0000, 15, 0, 3, 100, "R3 below15");
    apply(7, 16'hFFFF, 16'h0000, 15, 0, 3, 100, "R3 hi15");
    apply(8, 16'hFFFF, 16'h0000, 15, 0, 3, 100, "R3 above15");
    apply(-2, 16'hFFFF, 16'h0000, 4, 0, 0, 5, "R3 lo4");
    apply(2, 16'hFFFF, 16'h0000, 4, 0, 0, 5, "R3 above4");
    apply(0, 16'hFFFF, 16'h0000, 1, 0, 0, 5, "R3 L1 zero");
    apply(-1, 16'hFFFF, 16'h0000, 1, 0, 0, 5, "R3 L1 neg");
    // R5 length zero
    apply(0, 16'hFFFF, 16'h0000, 0, 9, 5, 7, "R5 len0");
    // R2 alternate selects length 1
    apply(0, 16'hFFFF, 16'h0020, 0, 9, 5, 7, "R2 alt");
    apply(-4, 16'hFFFF, 16'h0020, 15, 5, 5, 7, "R2 alt narrow");
    // R1 negative position, inactive slot, R9 evm without window
    apply(0, 16'hFFFF, 16'h0000, 5, 5, -1, 7, "R1 negpos");
    apply(0, 16'hFFF7, 16'h0000, 5, 5, 3, 7, "R1 inactive");
    apply(12, 16'h0008, 16'h0000, 2, 2, 3, 7, "R1 evm nowin");
    // R6 R7 boundary
    apply(0, 16'h0001, 16'h0000, 3, 3, 0, 4095, "R7 max");
    apply(0, 16'h0001, 16'h0000, 3, 3, 0, 4096, "R6 over");
    apply(0, 16'h0001, 16'h0000, 3, 3, 0, 65535, "R6 top");
    for (int i = 0; i < 400; i++) begin
      int ofs, pos, raw;
      ofs = int'($urandom_range(20)) - 10;
      pos = int'($urandom_range(19)) - 3;
      raw = ($urandom_range(3) == 0) ? int'($urandom_range(65535)) : int'($urandom_range(4095));
      apply(ofs, 16'($urandom), 16'($urandom), int'($urandom_range(15)),
            int'($urandom_range(15)), pos, raw, "rand");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule